// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a 32-bit RISC pipeline. It decides whether an interrupt is taken at an instruction boundary, and then runs the exception entry sequence on a simple 32-bit memory port. Two sources compete for entry. The first is an external request coded as a 4-bit level. The second is an internal peripheral request that is posted with its own level and vector number. The internal request is held inside the block until it is taken. The core reports each instruction boundary with a strobe. It also raises a flag when a delayed-branch slot is still to be executed, and no entry may start while that flag is high.

On entry the block pushes the status word and then the return PC onto the stack. It then reads the handler address from the vector table, and hands the new PC, SP and SR back to the core with a one-cycle update pulse.

After reset the block fetches the start PC and the start stack pointer from the first two words of memory. It presents them with a status word that masks every level.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block reads the word at address 0 as the new PC and the word at address 4 as the new SP. It then raises `upd_valid_o` with `new_sr_o` = 0x000000F0.
- R2: A selected request is taken only when its level is strictly greater than the mask in SR bits 7:4. A request at or below the mask starts nothing and stays pending.
- R3: An entry caused by the external source uses vector number 64 + level/2, with the division rounding down.
- R4: When both sources are pending, the external source wins only if its level is strictly greater than the internal level. Otherwise the internal level and its posted vector are used.
- R5: Entry first writes the current SR to SP-4 and then writes the return PC to SP-8. Both are 32-bit writes, with `mem_we_o` = 1.
- R6: Entry then reads the 32-bit word at VBR + 4*vector, and this word becomes `new_pc_o`.
- R7: At the end of entry, `new_sp_o` is SP-8. `new_sr_o` is the old SR with bits 7:4 replaced by the taken level and every other bit kept.
- R8: A taken internal request is cleared, so it does not fire again. The external level is never cleared by the block.
- R9: No entry starts without a boundary strobe, or at a boundary where the delayed-branch flag is high.
- R10: `busy_o` stays high for at least 13 consecutive cycles for every entry.
- R11: `ack_o` is a one-cycle pulse in the first busy cycle of an entry. It carries the taken level on `ack_level_o`.
- R12: While `mem_req_o` is high and `mem_ready_i` is low, the address, the data and the write flag on the memory port do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary reached |
| delay_slot_i | input | 1 | A delayed-branch slot is still to execute |
| ext_level_i | input | 4 | External request level, 0 means none |
| int_req_i | input | 1 | Post an internal request (loads level and vector) |
| int_level_i | input | 4 | Level of the posted internal request |
| int_vector_i | input | 8 | Vector number of the posted internal request |
| cur_pc_i | input | 32 | Return PC from the core |
| cur_sp_i | input | 32 | Current stack pointer |
| cur_sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid when ready is high |
| mem_ready_i | input | 1 | Access completes in this cycle |
| busy_o | output | 1 | Reset fetch or entry in progress |
| ack_o | output | 1 | Entry accepted pulse |
| ack_level_o | output | 4 | Level that was accepted |
| upd_valid_o | output | 1 | New PC/SP/SR valid for one cycle |
| new_pc_o | output | 32 | New PC |
| new_sp_o | output | 32 | New SP |
| new_sr_o | output | 32 | New SR |

## Verification
The hardest situation to reach is a boundary where both sources are pending and their levels are equal or differ by one, with the mask sitting just below them. This is the case where the arbitration rule, the strict mask compare and the clearing of the internal request all act together. It is also the case where a stale internal request would wrongly fire a second time. The random phase draws levels and masks from a narrow band, so that these near ties occur often. It posts new internal requests between attempts and leaves the external level in place across several boundaries. It also drops a delayed-branch flag on some strobes. A random memory ready signal stretches every step of the sequence.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_RST_PC,
    ST_RST_SP,
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_FETCH_VEC,
    ST_DONE
  } entry_state_e;

  // Position of the interrupt mask field inside the status word.
  localparam int SR_MASK_LSB = 4;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int LVL_W        = 4,
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 64
) (
  input  logic [LVL_W-1:0] ext_level_i,
  input  logic [LVL_W-1:0] int_level_i,
  input  logic [VEC_W-1:0] int_vector_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic             sel_int_o,
  output logic [LVL_W-1:0] sel_level_o,
  output logic [VEC_W-1:0] sel_vector_o,
  output logic             above_o
);

  logic             ext_wins;
  logic [VEC_W-1:0] ext_vector;

  always_comb begin
    ext_wins     = ext_level_i > int_level_i;
    ext_vector   = VEC_W'(EXT_VEC_BASE) + VEC_W'(ext_level_i >> 1);
    sel_int_o    = !ext_wins && (int_level_i != '0);
    sel_level_o  = ext_wins ? ext_level_i : int_level_i;
    sel_vector_o = ext_wins ? ext_vector  : int_vector_i;
    above_o      = sel_level_o > mask_i;
  end

endmodule

// File: rtl/irq_int_pending.sv
module irq_int_pending #(
  parameter int LVL_W = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             clear_i,
  output logic [LVL_W-1:0] level_o,
  output logic [VEC_W-1:0] vector_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o  <= '0;
      vector_o <= '0;
    end else if (load_i) begin
      level_o  <= level_i;
      vector_o <= vector_i;
    end else if (clear_i) begin
      level_o  <= '0;
    end
  end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int LVL_W        = 4,
  parameter int VEC_W        = 8,
  parameter int ENTRY_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_req_i,
  input  logic [LVL_W-1:0]  take_level_i,
  input  logic [VEC_W-1:0]  take_vector_i,
  input  logic [DATA_W-1:0] cur_pc_i,
  input  logic [DATA_W-1:0] cur_sp_i,
  input  logic [DATA_W-1:0] cur_sr_i,
  input  logic [DATA_W-1:0] vbr_i,
  output logic              idle_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              ack_o,
  output logic [LVL_W-1:0]  ack_level_o,
  output logic              upd_valid_o,
  output logic [DATA_W-1:0] new_pc_o,
  output logic [DATA_W-1:0] new_sp_o,
  output logic [DATA_W-1:0] new_sr_o
);

  localparam int                CNT_W    = $clog2(ENTRY_CYCLES + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(ENTRY_CYCLES);
  localparam logic [DATA_W-1:0] WORD     = DATA_W'(4);
  localparam logic [DATA_W-1:0] SR_RESET =
    DATA_W'(((1 << LVL_W) - 1) << SR_MASK_LSB);

  entry_state_e      state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] lat_sp, lat_pc, lat_sr, lat_vbr;
  logic [LVL_W-1:0]  lat_lvl;
  logic [VEC_W-1:0]  lat_vec;
  logic              xfer;
  logic [DATA_W-1:0] vec_addr;
  logic [DATA_W-1:0] sr_next;

  always_comb begin
    xfer     = mem_req_o && mem_ready_i;
    vec_addr = lat_vbr + (DATA_W'(lat_vec) << 2);
    sr_next  = lat_sr;
    sr_next[SR_MASK_LSB +: LVL_W] = lat_lvl;
    idle_o   = (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RST_PC;
      cnt         <= '0;
      mem_req_o   <= 1'b1;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      ack_o       <= 1'b0;
      ack_level_o <= '0;
      upd_valid_o <= 1'b0;
      new_pc_o    <= '0;
      new_sp_o    <= '0;
      new_sr_o    <= '0;
      lat_sp      <= '0;
      lat_pc      <= '0;
      lat_sr      <= '0;
      lat_vbr     <= '0;
      lat_lvl     <= '0;
      lat_vec     <= '0;
    end else begin
      ack_o       <= 1'b0;
      upd_valid_o <= 1'b0;
      if (state != ST_IDLE && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      case (state)
        ST_RST_PC: if (xfer) begin
          new_pc_o   <= mem_rdata_i;
          mem_addr_o <= WORD;
          state      <= ST_RST_SP;
        end
        ST_RST_SP: if (xfer) begin
          new_sp_o    <= mem_rdata_i;
          new_sr_o    <= SR_RESET;
          upd_valid_o <= 1'b1;
          mem_req_o   <= 1'b0;
          state       <= ST_IDLE;
        end
        ST_IDLE: if (take_req_i) begin
          lat_sp      <= cur_sp_i;
          lat_pc      <= cur_pc_i;
          lat_sr      <= cur_sr_i;
          lat_vbr     <= vbr_i;
          lat_lvl     <= take_level_i;
          lat_vec     <= take_vector_i;
          ack_o       <= 1'b1;
          ack_level_o <= take_level_i;
          cnt         <= CNT_W'(1);
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= cur_sp_i - WORD;
          mem_wdata_o <= cur_sr_i;
          state       <= ST_PUSH_SR;
        end
        ST_PUSH_SR: if (xfer) begin
          mem_addr_o  <= lat_sp - (WORD << 1);
          mem_wdata_o <= lat_pc;
          state       <= ST_PUSH_PC;
        end
        ST_PUSH_PC: if (xfer) begin
          mem_we_o   <= 1'b0;
          mem_addr_o <= vec_addr;
          state      <= ST_FETCH_VEC;
        end
        ST_FETCH_VEC: if (xfer) begin
          mem_req_o <= 1'b0;
          new_pc_o  <= mem_rdata_i;
          state     <= ST_DONE;
        end
        ST_DONE: if (cnt >= CNT_MAX) begin
          new_sp_o    <= lat_sp - (WORD << 1);
          new_sr_o    <= sr_next;
          upd_valid_o <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int LVL_W        = 4,
  parameter int VEC_W        = 8,
  parameter int EXT_VEC_BASE = 64,
  parameter int ENTRY_CYCLES = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              delay_slot_i,
  input  logic [LVL_W-1:0]  ext_level_i,
  input  logic              int_req_i,
  input  logic [LVL_W-1:0]  int_level_i,
  input  logic [VEC_W-1:0]  int_vector_i,
  input  logic [DATA_W-1:0] cur_pc_i,
  input  logic [DATA_W-1:0] cur_sp_i,
  input  logic [DATA_W-1:0] cur_sr_i,
  input  logic [DATA_W-1:0] vbr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic [LVL_W-1:0]  ack_level_o,
  output logic              upd_valid_o,
  output logic [DATA_W-1:0] new_pc_o,
  output logic [DATA_W-1:0] new_sp_o,
  output logic [DATA_W-1:0] new_sr_o
);

  logic [LVL_W-1:0] pend_level;
  logic [VEC_W-1:0] pend_vector;
  logic             sel_int;
  logic [LVL_W-1:0] sel_level;
  logic [VEC_W-1:0] sel_vector;
  logic             above;
  logic             idle;
  logic             take;

  // An entry may start only at a clean boundary, while the core is not
  // still absorbing the previous update.
  assign take   = idle && boundary_i && !delay_slot_i && !upd_valid_o && above;
  assign busy_o = !idle;

  irq_int_pending #(.LVL_W(LVL_W), .VEC_W(VEC_W)) pend_i (
    .clk      (clk),
    .rst      (rst),
    .load_i   (int_req_i),
    .level_i  (int_level_i),
    .vector_i (int_vector_i),
    .clear_i  (take && sel_int),
    .level_o  (pend_level),
    .vector_o (pend_vector)
  );

  irq_arbiter #(.LVL_W(LVL_W), .VEC_W(VEC_W), .EXT_VEC_BASE(EXT_VEC_BASE)) arb_i (
    .ext_level_i  (ext_level_i),
    .int_level_i  (pend_level),
    .int_vector_i (pend_vector),
    .mask_i       (cur_sr_i[SR_MASK_LSB +: LVL_W]),
    .sel_int_o    (sel_int),
    .sel_level_o  (sel_level),
    .sel_vector_o (sel_vector),
    .above_o      (above)
  );

  irq_entry_fsm #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .ENTRY_CYCLES(ENTRY_CYCLES)
  ) fsm_i (
    .clk           (clk),
    .rst           (rst),
    .take_req_i    (take),
    .take_level_i  (sel_level),
    .take_vector_i (sel_vector),
    .cur_pc_i      (cur_pc_i),
    .cur_sp_i      (cur_sp_i),
    .cur_sr_i      (cur_sr_i),
    .vbr_i         (vbr_i),
    .idle_o        (idle),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_rdata_i   (mem_rdata_i),
    .mem_ready_i   (mem_ready_i),
    .ack_o         (ack_o),
    .ack_level_o   (ack_level_o),
    .upd_valid_o   (upd_valid_o),
    .new_pc_o      (new_pc_o),
    .new_sp_o      (new_sp_o),
    .new_sr_o      (new_sr_o)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_entry_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int LVL_W        = 4,
  parameter int ENTRY_CYCLES = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              boundary_i,
  input logic              delay_slot_i,
  input logic [DATA_W-1:0] cur_sp_i,
  input logic [DATA_W-1:0] cur_sr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i,
  input logic              busy_o,
  input logic              ack_o,
  input logic [LVL_W-1:0]  ack_level_o,
  input logic              upd_valid_o,
  input logic [DATA_W-1:0] new_sr_o
);

  localparam int CW = $clog2(ENTRY_CYCLES + 2);

  logic [CW-1:0]    busy_cnt;
  logic             in_entry;
  logic [LVL_W-1:0] seen_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      in_entry <= 1'b0;
      seen_lvl <= '0;
    end else begin
      if (!busy_o) busy_cnt <= '0;
      else if (busy_cnt != {CW{1'b1}}) busy_cnt <= busy_cnt + 1'b1;
      if (ack_o) begin
        in_entry <= 1'b1;
        seen_lvl <= ack_level_o;
      end else if (!busy_o) begin
        in_entry <= 1'b0;
      end
    end
  end

  a_r11_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  a_r2_above_mask: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> ack_level_o > $past(cur_sr_i[SR_MASK_LSB +: LVL_W]));

  a_r9_clean_boundary: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> ($past(boundary_i) && !$past(delay_slot_i)));

  a_r5_first_push: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (mem_req_o && mem_we_o && mem_addr_o == $past(cur_sp_i) - 32'd4
               && mem_wdata_o == $past(cur_sr_i)));

  a_r12_hold_port: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  a_r10_min_busy: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && in_entry) |-> busy_cnt >= CW'(ENTRY_CYCLES));

  a_r7_new_mask: assert property (@(posedge clk) disable iff (rst)
    (upd_valid_o && in_entry) |-> new_sr_o[SR_MASK_LSB +: LVL_W] == seen_lvl);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DATA_W(DATA_W), .LVL_W(LVL_W), .ENTRY_CYCLES(ENTRY_CYCLES)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .boundary_i   (boundary_i),
  .delay_slot_i (delay_slot_i),
  .cur_sp_i     (cur_sp_i),
  .cur_sr_i     (cur_sr_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i),
  .busy_o       (busy_o),
  .ack_o        (ack_o),
  .ack_level_o  (ack_level_o),
  .upd_valid_o  (upd_valid_o),
  .new_sr_o     (new_sr_o)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boundary = 1'b0, dslot = 1'b0;
  logic [3:0]  ext_level = '0;
  logic        int_req = 1'b0;
  logic [3:0]  int_level = '0;
  logic [7:0]  int_vector = '0;
  logic [31:0] cur_pc = 32'h0000_1000, cur_sp = 32'h0000_8000;
  logic [31:0] cur_sr = 32'h0000_00F0, vbr = 32'h0002_0000;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, ack, upd;
  logic [3:0]  ack_level;
  logic [31:0] new_pc, new_sp, new_sr;

  int tests = 0, fails = 0;
  int wr_n = 0, rd_n = 0;
  logic [31:0] wr_a [2];
  logic [31:0] wr_d [2];
  logic [31:0] rd_a;
  logic [3:0]  m_ipl = '0;
  logic [7:0]  m_ivec = '0;

  always #5 clk = ~clk;

  function automatic logic [31:0] fmem(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  assign mem_rdata = fmem(mem_addr);

  irq_entry_seq dut_i (
    .clk(clk), .rst(rst), .boundary_i(boundary), .delay_slot_i(dslot),
    .ext_level_i(ext_level), .int_req_i(int_req), .int_level_i(int_level),
    .int_vector_i(int_vector), .cur_pc_i(cur_pc), .cur_sp_i(cur_sp),
    .cur_sr_i(cur_sr), .vbr_i(vbr), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .busy_o(busy), .ack_o(ack), .ack_level_o(ack_level),
    .upd_valid_o(upd), .new_pc_o(new_pc), .new_sp_o(new_sp), .new_sr_o(new_sr)
  );

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ready) begin
      if (mem_we) begin
        if (wr_n < 2) begin
          wr_a[wr_n] = mem_addr;
          wr_d[wr_n] = mem_wdata;
        end
        wr_n++;
      end else begin
        rd_a = mem_addr;
        rd_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic post_int(input logic [3:0] lvl, input logic [7:0] vec);
    @(negedge clk);
    int_req = 1'b1; int_level = lvl; int_vector = vec;
    @(negedge clk);
    int_req = 1'b0;
    m_ipl = lvl; m_ivec = vec;
  endtask

  task automatic set_mask(input logic [3:0] m);
    cur_sr = (cur_sr & ~32'hF0) | (32'(m) << 4);
  endtask

  task automatic attempt(input logic [3:0] ext, input bit ds, input bit bnd);
    bit          sel_ext, acc;
    logic [3:0]  lvl;
    logic [7:0]  vec;
    logic [31:0] sp0, pc0, sr0, exp_sr, vaddr;
    int          bc, n;
    sel_ext = ext > m_ipl;
    lvl     = sel_ext ? ext : m_ipl;
    vec     = sel_ext ? (8'd64 + 8'(ext >> 1)) : m_ivec;
    acc     = bnd && !ds && (lvl > cur_sr[7:4]);
    @(negedge clk);
    ext_level = ext; dslot = ds; boundary = bnd;
    wr_n = 0; rd_n = 0;
    sp0 = cur_sp; pc0 = cur_pc; sr0 = cur_sr;
    @(negedge clk);
    boundary = 1'b0; dslot = 1'b0;
    // R2 R9: acceptance decision
    check(ack == acc, "R2/R9 accept decision", 32'(ack), 32'(acc));
    if (acc && ack) begin
      check(ack_level == lvl, "R11 ack level (R4 choice)", 32'(ack_level), 32'(lvl));
      bc = 0; n = 0;
      while (!upd && n < 400) begin
        if (busy) bc++;
        @(negedge clk);
        n++;
      end
      check(upd, "R7 update pulse", 32'(upd), 1);
      check(bc >= 13, "R10 busy length", 32'(bc), 13);
      check(wr_n == 2 && wr_a[0] == sp0 - 4 && wr_d[0] == sr0,
            "R5 push SR", wr_a[0], sp0 - 4);
      check(wr_a[1] == sp0 - 8 && wr_d[1] == pc0, "R5 push PC", wr_d[1], pc0);
      vaddr = vbr + (32'(vec) << 2);
      check(rd_n == 1 && rd_a == vaddr, "R3/R6 vector address", rd_a, vaddr);
      check(new_pc == fmem(vaddr), "R6 new PC", new_pc, fmem(vaddr));
      check(new_sp == sp0 - 8, "R7 new SP", new_sp, sp0 - 8);
      exp_sr = (sr0 & ~32'hF0) | (32'(lvl) << 4);
      check(new_sr == exp_sr, "R7 new SR", new_sr, exp_sr);
      cur_pc = new_pc; cur_sp = new_sp; cur_sr = new_sr;
      if (!sel_ext) m_ipl = '0;   // R8 internal request clears
      @(negedge clk);
    end else begin
      @(negedge clk);
      check(!busy && !mem_req && wr_n == 0, "R2/R9 nothing started",
            32'(busy), 0);
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1: reset state before the fetch completes
    check(busy && mem_req && !mem_we && mem_addr == 0 && !ack,
          "R1 reset state", mem_addr, 0);
    rst = 1'b0;
    n = 0;
    while (!upd && n < 200) begin @(negedge clk); n++; end
    check(new_pc == fmem(32'h0), "R1 reset PC", new_pc, fmem(32'h0));
    check(new_sp == fmem(32'h4), "R1 reset SP", new_sp, fmem(32'h4));
    check(new_sr == 32'hF0, "R1 reset SR", new_sr, 32'hF0);
    cur_sp = 32'h0000_8000; cur_sr = new_sr;
    @(negedge clk);

    // R2: level 15 under full mask is refused
    attempt(4'd15, 1'b0, 1'b1);
    cur_sr = 32'h0000_0331;
    attempt(4'd3, 1'b0, 1'b1);           // R2 equal to mask: refused
    attempt(4'd5, 1'b0, 1'b1);           // R3 ext level 5 -> vector 66
    attempt(4'd5, 1'b0, 1'b1);           // R8 ext stays but now masked
    set_mask(4'd1);
    attempt(4'd9, 1'b1, 1'b1);           // R9 delay slot blocks
    attempt(4'd9, 1'b0, 1'b0);           // R9 no strobe, no entry
    set_mask(4'd1);
    post_int(4'd6, 8'h21);
    attempt(4'd6, 1'b0, 1'b1);           // R4 tie: internal wins
    set_mask(4'd0);
    attempt(4'd0, 1'b0, 1'b1);           // R8 cleared internal: nothing
    post_int(4'd6, 8'h22);
    set_mask(4'd0);
    attempt(4'd7, 1'b0, 1'b1);           // R4 ext above internal wins
    set_mask(4'd0);
    attempt(4'd0, 1'b0, 1'b1);           // R8 internal still pending
    set_mask(4'd0);
    attempt(4'd0, 1'b0, 1'b1);

    for (int i = 0; i < 200; i++) begin
      if (($urandom % 10) < 3)
        post_int(4'(4 + $urandom % 8), 8'($urandom));
      if (($urandom % 10) < 5) set_mask(4'(3 + $urandom % 8));
      cur_pc = $urandom & 32'hFFFF_FFFE;
      attempt(4'(3 + $urandom % 10), ($urandom % 5) == 0, ($urandom % 10) != 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule